// File: doc/BRIEF.md
# Periodic Output Impedance Calibration Controller

This block keeps two drive strength codes for an output driver, one for the pull-up half and one for the pull-down half. Each code is a plain unsigned binary number, because it selects binary-weighted impedance legs. A free-running cycle counter expires every `PERIOD` cycles. At each expiry the block samples raise and lower requests from an external sense circuit, one pair per half. It then moves that half's evaluated code one step toward the requested direction. Codes saturate at the ends of their range and never wrap.

An evaluated code first waits in a per-half pending register. The pull-up code is copied to the driver only while the driver outputs 0 or is high-impedance, that is, while the pull-up legs are off. The pull-down code is copied only while the driver outputs 1 or is high-impedance. The edge the driver is producing is therefore never disturbed by a code change. If a later evaluation arrives while a half is still busy, it overwrites that half's pending value. The half then takes the newest value once it goes idle. Calibration repeats without end, so the codes track slow supply and temperature drift.

Top module: `imp_cal_top`

## Requirements
- R1: While reset (`rstN` low) is held and right after it is released, both `puCode` and `pdCode` equal mid-scale, 2^(CODE_W-1), which is 8 for CODE_W=4.
- R2: Evaluations happen only on the clock edge where the cycle counter holds PERIOD-1. The counter is 0 after reset, so the first evaluation falls on the PERIOD-th rising edge after reset release, and further evaluations follow every PERIOD edges. Between evaluations the pending codes do not change.
- R3: Each evaluation changes a pending code by at most one step.
- R4: At an evaluation, a half whose raise request is 1 and lower request is 0 goes up by one. A half whose lower request is 1 and raise request is 0 goes down by one. A half with both requests equal (both 0 or both 1) holds its value.
- R5: A pending code at all-ones does not go up, and one at all-zeros does not go down. Codes never wrap around.
- R6: `puCode` takes the pending pull-up value one edge after an edge where the driver was high-impedance (`drvOe`=0) or driving 0 (`drvOe`=1, `drvData`=0). After an edge where the driver was driving 1, `puCode` is unchanged.
- R7: `pdCode` takes the pending pull-down value one edge after an edge where the driver was high-impedance or driving 1. After an edge where the driver was driving 0, `pdCode` is unchanged.
- R8: A later evaluation overwrites a pending value that has not yet been applied. When the half goes idle, the applied code jumps straight to the newest pending value, even if that value is more than one step away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| drvOe | input | 1 | Driver output enable; 0 means high-impedance |
| drvData | input | 1 | Value the driver is producing when enabled |
| puUp | input | 1 | Sense circuit asks for a stronger pull-up code |
| puDn | input | 1 | Sense circuit asks for a weaker pull-up code |
| pdUp | input | 1 | Sense circuit asks for a stronger pull-down code |
| pdDn | input | 1 | Sense circuit asks for a weaker pull-down code |
| puCode | output | CODE_W | Applied pull-up drive code |
| pdCode | output | CODE_W | Applied pull-down drive code |

## Verification
The assertions assume that the sense requests and the driver state are synchronous to `clk` and settled before each rising edge. They also assume that a request pair with both bits high is a legal input, which the block treats as a hold. The bench changes every input only at the falling edge. Across the exhaustive sweep it drives all sixteen request combinations, including both-high, against every driver state, so every input pattern the assertions reason about is actually reached.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;

  // Strobes from the control half to the code datapath
  typedef struct packed {
    logic evalStb;  // counter expired: step the pending codes
    logic puLoad;   // pull-up legs idle: pull-up code may be applied
    logic pdLoad;   // pull-down legs idle: pull-down code may be applied
  } calStrb_t;

endpackage

// File: rtl/imp_cal_ctrl.sv
module imp_cal_ctrl
  import imp_cal_pkg::*;
#(
  parameter int PERIOD = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     drvOe,
  input  logic     drvData,
  output calStrb_t strb
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] periodCnt;
  logic             expired;

  assign expired = (periodCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (expired) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  // Each half may be refreshed only while its legs carry no current
  always_comb begin
    strb.evalStb = expired;
    strb.puLoad  = !drvOe || !drvData;
    strb.pdLoad  = !drvOe ||  drvData;
  end

endmodule

// File: rtl/imp_cal_dp.sv
module imp_cal_dp
  import imp_cal_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrb_t          strb,
  input  logic              puUp,
  input  logic              puDn,
  input  logic              pdUp,
  input  logic              pdDn,
  output logic [CODE_W-1:0] pendPu,
  output logic [CODE_W-1:0] pendPd,
  output logic [CODE_W-1:0] puCode,
  output logic [CODE_W-1:0] pdCode
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;
  localparam int HALVES = 2;  // index 0: pull-up, index 1: pull-down

  logic [HALVES-1:0]             raiseReq;
  logic [HALVES-1:0]             lowerReq;
  logic [HALVES-1:0]             loadReq;
  logic [HALVES-1:0][CODE_W-1:0] pendQ;
  logic [HALVES-1:0][CODE_W-1:0] codeQ;

  assign raiseReq = {pdUp, puUp};
  assign lowerReq = {pdDn, puDn};
  assign loadReq  = {strb.pdLoad, strb.puLoad};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [CODE_W-1:0] stepNext;

    // One saturating step per evaluation; contradictory requests hold
    always_comb begin
      stepNext = pendQ[h];
      if (raiseReq[h] && !lowerReq[h] && (pendQ[h] != MAX_CODE)) begin
        stepNext = pendQ[h] + 1'b1;
      end else if (lowerReq[h] && !raiseReq[h] && (pendQ[h] != '0)) begin
        stepNext = pendQ[h] - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[h] <= MID_CODE;
      end else if (strb.evalStb) begin
        pendQ[h] <= stepNext;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeQ[h] <= MID_CODE;
      end else if (loadReq[h]) begin
        codeQ[h] <= pendQ[h];
      end
    end
  end

  assign pendPu = pendQ[0];
  assign pendPd = pendQ[1];
  assign puCode = codeQ[0];
  assign pdCode = codeQ[1];

endmodule

// File: rtl/imp_cal_top.sv
module imp_cal_top
  import imp_cal_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int PERIOD = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              drvOe,
  input  logic              drvData,
  input  logic              puUp,
  input  logic              puDn,
  input  logic              pdUp,
  input  logic              pdDn,
  output logic [CODE_W-1:0] puCode,
  output logic [CODE_W-1:0] pdCode
);

  calStrb_t          strb;
  logic [CODE_W-1:0] pendPu;
  logic [CODE_W-1:0] pendPd;

  imp_cal_ctrl #(.PERIOD(PERIOD)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .drvOe   (drvOe),
    .drvData (drvData),
    .strb    (strb)
  );

  imp_cal_dp #(.CODE_W(CODE_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .puUp   (puUp),
    .puDn   (puDn),
    .pdUp   (pdUp),
    .pdDn   (pdDn),
    .pendPu (pendPu),
    .pendPd (pendPd),
    .puCode (puCode),
    .pdCode (pdCode)
  );

endmodule

// File: rtl/imp_cal_chk.sv
module imp_cal_chk #(
  parameter int CODE_W = 4,
  parameter int PERIOD = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              drvOe,
  input logic              drvData,
  input logic              puUp,
  input logic              puDn,
  input logic              pdUp,
  input logic              pdDn,
  input logic              evalStb,
  input logic [CODE_W-1:0] pendPu,
  input logic [CODE_W-1:0] pendPd,
  input logic [CODE_W-1:0] puCode,
  input logic [CODE_W-1:0] pdCode
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0]  LAST     = CNT_W'(PERIOD - 1);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  // Independent period tracker for the evaluation window
  logic [CNT_W-1:0] chkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt <= '0;
    end else if (chkCnt == LAST) begin
      chkCnt <= '0;
    end else begin
      chkCnt <= chkCnt + 1'b1;
    end
  end

  AST_EVAL_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    evalStb == (chkCnt == LAST)); // R2

  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !evalStb |=> ($stable(pendPu) && $stable(pendPd))); // R2

  AST_PU_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    evalStb |=> ((pendPu == $past(pendPu)) || (pendPu == $past(pendPu) + 1'b1) ||
                 (pendPu == $past(pendPu) - 1'b1))); // R3

  AST_PD_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    evalStb |=> ((pendPd == $past(pendPd)) || (pendPd == $past(pendPd) + 1'b1) ||
                 (pendPd == $past(pendPd) - 1'b1))); // R3

  AST_PU_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && (puUp == puDn)) |=> $stable(pendPu)); // R4

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && (pdUp == pdDn)) |=> $stable(pendPd)); // R4

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && (pendPu == MAX_CODE)) |=> (pendPu != '0)); // R5

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (evalStb && (pendPd == '0)) |=> (pendPd != MAX_CODE)); // R5

  AST_PU_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (drvOe && drvData) |=> $stable(puCode)); // R6

  AST_PU_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    (!drvOe || !drvData) |=> (puCode == $past(pendPu))); // R6

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (drvOe && !drvData) |=> $stable(pdCode)); // R7

  AST_PD_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    (!drvOe || drvData) |=> (pdCode == $past(pendPd))); // R7

endmodule

bind imp_cal_top imp_cal_chk #(.CODE_W(CODE_W), .PERIOD(PERIOD)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .drvOe   (drvOe),
  .drvData (drvData),
  .puUp    (puUp),
  .puDn    (puDn),
  .pdUp    (pdUp),
  .pdDn    (pdDn),
  .evalStb (strb.evalStb),
  .pendPu  (pendPu),
  .pendPd  (pendPd),
  .puCode  (puCode),
  .pdCode  (pdCode)
);

// File: tb/imp_cal_top_tb_top.sv
`timescale 1ns/1ps
module imp_cal_top_tb_top;

  localparam int CODE_W = 4;
  localparam int PERIOD = 8;
  localparam int MAXC   = (1 << CODE_W) - 1;
  localparam int MIDC   = 1 << (CODE_W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic drvOe = 1'b0, drvData = 1'b0;
  logic puUp = 1'b0, puDn = 1'b0, pdUp = 1'b0, pdDn = 1'b0;
  logic [CODE_W-1:0] puCode, pdCode;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model of the expected state
  int mCnt, mPendPu, mPendPd, mPu, mPd;

  always #4 clk = ~clk;  // 125 MHz

  imp_cal_top #(.CODE_W(CODE_W), .PERIOD(PERIOD)) dut_i (
    .clk, .rstN, .drvOe, .drvData, .puUp, .puDn, .pdUp, .pdDn, .puCode, .pdCode
  );

  function automatic int nextCode(int c, logic up, logic dn);
    if (up && !dn) return (c == MAXC) ? c : c + 1;
    if (dn && !up) return (c == 0) ? c : c - 1;
    return c;
  endfunction

  task automatic checkCodes(string tag);
    nChecks++;
    if (int'(puCode) != mPu) begin
      nFails++;
      $display("FAIL %s puCode actual=%0d expected=%0d at %0t", tag, puCode, mPu, $time);
    end
    nChecks++;
    if (int'(pdCode) != mPd) begin
      nFails++;
      $display("FAIL %s pdCode actual=%0d expected=%0d at %0t", tag, pdCode, mPd, $time);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, check at the next fall
  task automatic stepCycle(logic oe, logic d, logic pu_u, logic pu_d,
                           logic pd_u, logic pd_d, string tag);
    drvOe = oe; drvData = d; puUp = pu_u; puDn = pu_d; pdUp = pd_u; pdDn = pd_d;
    @(posedge clk);
    if (!oe || !d) mPu = mPendPu;
    if (!oe || d)  mPd = mPendPd;
    if (mCnt == PERIOD - 1) begin
      mCnt    = 0;
      mPendPu = nextCode(mPendPu, pu_u, pu_d);
      mPendPd = nextCode(mPendPd, pd_u, pd_d);
    end else begin
      mCnt++;
    end
    @(negedge clk);
    checkCodes(tag);
  endtask

  task automatic runPeriods(int n, logic oe, logic d, logic pu_u, logic pu_d,
                            logic pd_u, logic pd_d, string tag);
    for (int i = 0; i < n * PERIOD; i++) stepCycle(oe, d, pu_u, pu_d, pd_u, pd_d, tag);
  endtask

  initial begin
    #1 rstN = 1'b0;
    mCnt = 0; mPendPu = MIDC; mPendPd = MIDC; mPu = MIDC; mPd = MIDC;
    repeat (3) @(negedge clk);
    checkCodes("R1 in reset");
    rstN = 1'b1;
    checkCodes("R1 after release");

    // R2 timing, R3 single steps: high-impedance, pull-up raised, pull-down lowered
    runPeriods(3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 R3 ramp");
    // R4 hold with no requests and with contradictory requests
    runPeriods(2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 idle hold");
    runPeriods(2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R4 both hold");
    // R5 saturation at both ends, then reversed
    runPeriods(12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 saturate");
    runPeriods(18, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R5 saturate reverse");
    // R6: driving 1 blocks pull-up updates; R8: pending climbs two steps
    runPeriods(2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R6 pull-up busy");
    stepCycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 overwrite jump");
    // R7: driving 0 blocks pull-down updates
    runPeriods(2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R7 pull-down busy");
    stepCycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 pull-down jump");

    // Exhaustive sweep: all request pairs against all driver states
    for (int c = 0; c < 64; c++) begin
      logic [5:0] v;
      v = 6'(c);
      runPeriods(1, v[5], v[4], v[3], v[2], v[1], v[0], "R4 R6 R7 sweep");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule